// File: doc/BRIEF.md
# Triggered Acquisition Sequencer

The sequencer decides which samples of a free-running converter stream are written into a sample buffer. A scan divider thins the timebase down to the sample rate. One trigger line is qualified out of four candidates, and one of four capture modes sets where the record sits relative to the trigger. Every accepted sample leaves the block as a write strobe with an address and data. The block also gives a per-record done pulse, a sticky acquisition-done flag and a busy flag.

In the two modes that capture only after the trigger (immediate and delayed), the block can re-arm by itself and collect several records back to back. In the two modes that keep history before the trigger, the buffer is filled as a ring while armed. When the record is complete, the block reports where the record's oldest sample sits. It also raises a flag if the ring held fewer pre-trigger samples than were asked for.

Top module: `acq_trig_seq`

## Requirements
- R1: After reset, `busy_o`, `wr_en_o`, `rec_done_o`, `acq_done_o` and `pre_short_o` are 0.
- R2: A `start_i` pulse while idle latches the configuration. In the next cycle `busy_o` is 1 and `acq_done_o` is 0. The block is then armed.
- R3: While capturing, successive samples are taken `scan_i` cycles apart (1 to 65535; 0 acts as 1).
- R4: `src_i` selects the trigger: 0 software, 1 external, 2 analog flag, 3 sync input. Activity on any unselected line has no effect.
- R5: A software trigger acts in the cycle it is seen. In mode 0, the first sample written is the converter value of the following cycle.
- R6: The external, analog and sync lines pass through two synchronizing flops and an edge detector. The edge is rising when `fall_i`=0 and falling when `fall_i`=1. In mode 0, the first sample is the value three cycles after the line changes.
- R7: Mode 0 (post) writes `n_i` samples to consecutive addresses, the first record starting at address 0.
- R8: Mode 1 (delayed) starts sampling D=`dly_i`+1 cycles later than mode 0 would.
- R9: Mode 2 (pre) fills the buffer as a ring while armed. On the trigger it ends the record with the sample of the trigger cycle, keeping the latest `n_i` samples. `rd_start_o` points to the oldest of them.
- R10: Mode 3 (middle) keeps up to `pre_i` samples up to and including the trigger cycle, then `n_i`-`pre_i` samples after it. If fewer pre-trigger samples were available, `pre_short_o` is 1 and the record is shorter.
- R11: With `retrig_i`=1 in mode 0 or 1, the block collects `rec_i` records and re-arms after the last sample of each one. A trigger that arrives before re-arm is ignored. In modes 2 and 3, `retrig_i` is ignored.
- R12: `rec_done_o` pulses once per record. At the end of the last record, `acq_done_o` is set and `busy_o` is cleared. `acq_done_o` stays set until the next start.
- R13: `abort_i` returns the block to idle from any state. In the next cycle `busy_o` is 0 and no further writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arm request |
| abort_i | input | 1 | Return to idle |
| mode_i | input | 2 | 0 post, 1 delayed, 2 pre, 3 middle |
| src_i | input | 2 | Trigger source select |
| fall_i | input | 1 | Falling-edge qualification for line sources |
| retrig_i | input | 1 | Automatic re-arm enable |
| scan_i | input | CW | Scan interval in timebase cycles |
| n_i | input | CW | Samples per record |
| dly_i | input | CW | Delay minus one, in timebase cycles |
| pre_i | input | CW | Pre-trigger samples in middle mode |
| rec_i | input | RW | Record count for re-arm |
| sw_trig_i | input | 1 | Software trigger command |
| ext_trig_i | input | 1 | External digital trigger line |
| ana_trig_i | input | 1 | Analog comparator flag |
| sync_trig_i | input | 1 | System synchronization line |
| adc_data_i | input | DW | Two's complement sample stream |
| wr_en_o | output | 1 | Sample write strobe |
| wr_addr_o | output | AW | Buffer write address |
| wr_data_o | output | DW | Sample written |
| rec_done_o | output | 1 | Record complete pulse |
| acq_done_o | output | 1 | Acquisition complete, sticky |
| busy_o | output | 1 | Acquisition in progress |
| rd_start_o | output | AW | Address of the oldest sample of the last record |
| pre_short_o | output | 1 | Fewer pre-trigger samples than requested |

## Verification
In pre mode, the trigger and a ring write can fall in the same cycle. That sample must be counted as the newest pre-trigger sample, and the record must end on it. With a scan interval of 1, every armed cycle writes, so each trigger in pre and middle mode coincides with a write. The bench rebuilds the buffer from the observed writes and compares the record found at `rd_start_o` with the converter values of the trigger cycle and the cycles before and after it. A second such case, a trigger level still held when a record ends and the block re-arms, is judged by the spacing between the first samples of successive records.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_DELAY, ST_CAPT} acq_st_e;
  typedef enum logic [1:0] {MODE_POST, MODE_DELAY, MODE_PRE, MODE_MID} acq_mode_e;
  typedef enum logic [1:0] {SRC_SW, SRC_EXT, SRC_ANA, SRC_SYNC} acq_src_e;
endpackage

// File: rtl/acq_scan_div.sv
module acq_scan_div #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [CW-1:0] scan_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload;

  assign reload = (scan_i == '0) ? '0 : scan_i - 1'b1;
  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= reload;
    else                cnt_q <= cnt_q - 1'b1;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i && scan_i > 1) |=> !tick_o);
endmodule

// File: rtl/acq_trig_qual.sv
module acq_trig_qual
  import acq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  acq_src_e src_i,
  input  logic     fall_i,
  input  logic     sw_i,
  input  logic     ext_i,
  input  logic     ana_i,
  input  logic     sync_i,
  output logic     hit_o
);
  localparam int NL = 3;
  logic [NL-1:0] raw, s1_q, s2_q, pv_q, edge_v;

  assign raw = {sync_i, ana_i, ext_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      pv_q <= '0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
      pv_q <= s2_q;
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_edge
    assign edge_v[g] = fall_i ? (pv_q[g] & ~s2_q[g]) : (s2_q[g] & ~pv_q[g]);
  end

  always_comb begin
    unique case (src_i)
      SRC_SW:   hit_o = sw_i;
      SRC_EXT:  hit_o = edge_v[0];
      SRC_ANA:  hit_o = edge_v[1];
      default:  hit_o = edge_v[2];
    endcase
  end

  // R6
  ext_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && src_i == SRC_EXT && !fall_i) |-> $past(ext_i, 2));
endmodule

// File: rtl/acq_trig_seq.sv
module acq_trig_seq
  import acq_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 5,
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    src_i,
  input  logic          fall_i,
  input  logic          retrig_i,
  input  logic [CW-1:0] scan_i,
  input  logic [CW-1:0] n_i,
  input  logic [CW-1:0] dly_i,
  input  logic [CW-1:0] pre_i,
  input  logic [RW-1:0] rec_i,
  input  logic          sw_trig_i,
  input  logic          ext_trig_i,
  input  logic          ana_trig_i,
  input  logic          sync_trig_i,
  input  logic [DW-1:0] adc_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rec_done_o,
  output logic          acq_done_o,
  output logic          busy_o,
  output logic [AW-1:0] rd_start_o,
  output logic          pre_short_o
);
  acq_st_e       st_q;
  acq_mode_e     mode_q;
  acq_src_e      src_q;
  logic          fall_q, retrig_q;
  logic [CW-1:0] scan_q, n_q, dly_q, post_q, need_q, samp_q, dcnt_q, len_q, len_nx;
  logic [RW-1:0] recs_q;
  logic [AW-1:0] ptr_q, ptr_nx;
  logic          ring, tick, hit, wr, accept, restart;
  logic [CW-1:0] pre_cl;

  assign pre_cl = (pre_i > n_i) ? n_i : pre_i;
  assign ring   = mode_q[1];

  acq_trig_qual u_qual (
    .clk_i, .rst_ni, .src_i(src_q), .fall_i(fall_q),
    .sw_i(sw_trig_i), .ext_i(ext_trig_i), .ana_i(ana_trig_i), .sync_i(sync_trig_i),
    .hit_o(hit)
  );

  acq_scan_div #(.CW(CW)) u_div (
    .clk_i, .rst_ni, .restart_i(restart), .scan_i(scan_q), .tick_o(tick)
  );

  always_comb begin
    wr      = tick && !abort_i && ((st_q == ST_ARMED && ring) || st_q == ST_CAPT);
    ptr_nx  = wr ? ptr_q + 1'b1 : ptr_q;
    if (wr && st_q == ST_ARMED) len_nx = (len_q >= need_q) ? len_q : len_q + 1'b1;
    else if (wr)                len_nx = len_q + 1'b1;
    else                        len_nx = len_q;
    accept  = st_q == ST_ARMED && hit && !abort_i;
    restart = (st_q == ST_IDLE && start_i) ||
              (accept && (mode_q == MODE_POST || (ring && post_q != '0))) ||
              (st_q == ST_DELAY && dcnt_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;     mode_q <= MODE_POST; src_q <= SRC_SW;
      fall_q <= 1'b0;      retrig_q <= 1'b0;
      scan_q <= '0; n_q <= '0; dly_q <= '0; post_q <= '0; need_q <= '0;
      samp_q <= '0; dcnt_q <= '0; len_q <= '0; recs_q <= '0; ptr_q <= '0;
      wr_en_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0; rec_done_o <= 1'b0;
      acq_done_o <= 1'b0; busy_o <= 1'b0; rd_start_o <= '0; pre_short_o <= 1'b0;
    end else begin
      wr_en_o    <= wr;
      wr_addr_o  <= ptr_q;
      wr_data_o  <= adc_data_i;
      rec_done_o <= 1'b0;
      if (abort_i) begin
        st_q   <= ST_IDLE;
        busy_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (start_i) begin
            mode_q   <= acq_mode_e'(mode_i);
            src_q    <= acq_src_e'(src_i);
            fall_q   <= fall_i;
            retrig_q <= retrig_i && !mode_i[1];
            scan_q   <= scan_i;
            n_q      <= n_i;
            dly_q    <= dly_i;
            post_q   <= (mode_i == MODE_PRE) ? '0 : n_i - pre_cl;
            need_q   <= (mode_i == MODE_PRE) ? n_i : pre_cl;
            recs_q   <= (rec_i == '0) ? RW'(1) : rec_i;
            ptr_q    <= '0;
            len_q    <= '0;
            busy_o   <= 1'b1;
            acq_done_o  <= 1'b0;
            pre_short_o <= 1'b0;
            st_q     <= ST_ARMED;
          end
          ST_ARMED: begin
            ptr_q <= ptr_nx;
            len_q <= len_nx;
            if (accept) begin
              if (ring) begin
                pre_short_o <= len_nx < need_q;
                if (post_q == '0) begin
                  rec_done_o <= 1'b1;
                  rd_start_o <= ptr_nx - len_nx[AW-1:0];
                  acq_done_o <= 1'b1;
                  busy_o     <= 1'b0;
                  st_q       <= ST_IDLE;
                end else begin
                  samp_q <= post_q;
                  st_q   <= ST_CAPT;
                end
              end else begin
                len_q <= '0;
                if (mode_q == MODE_DELAY) begin
                  dcnt_q <= dly_q;
                  st_q   <= ST_DELAY;
                end else begin
                  samp_q <= n_q;
                  st_q   <= ST_CAPT;
                end
              end
            end
          end
          ST_DELAY: begin
            if (dcnt_q == '0) begin
              samp_q <= n_q;
              st_q   <= ST_CAPT;
            end else dcnt_q <= dcnt_q - 1'b1;
          end
          default: begin
            ptr_q <= ptr_nx;
            len_q <= len_nx;
            if (wr) begin
              samp_q <= samp_q - 1'b1;
              if (samp_q == CW'(1)) begin
                rec_done_o <= 1'b1;
                rd_start_o <= ptr_nx - len_nx[AW-1:0];
                if (retrig_q && recs_q > RW'(1)) begin
                  recs_q <= recs_q - 1'b1;
                  st_q   <= ST_ARMED;
                end else begin
                  acq_done_o <= 1'b1;
                  busy_o     <= 1'b0;
                  st_q       <= ST_IDLE;
                end
              end
            end
          end
        endcase
      end
    end
  end

  // R13
  abort_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !wr_en_o));
  // R12
  done_with_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acq_done_o) |-> rec_done_o);
  // R2
  start_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i && !abort_i) |=> (busy_o && !acq_done_o));
  // R7
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> wr_addr_o == AW'($past(wr_addr_o) + 1'b1));
endmodule

// File: tb/tb_acq_trig_seq.sv
`timescale 1ns/1ps
module tb_acq_trig_seq;
  localparam int DW = 16, CW = 16, AW = 5, RW = 8, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic start = 0, abort = 0, fall = 0, retrig = 0;
  logic [1:0] mode = 0, src = 0;
  logic [CW-1:0] scan = 1, n = 1, dly = 0, pre = 0;
  logic [RW-1:0] recs = 1;
  logic sw = 0, ext = 0, ana = 0, syn = 0;
  logic [DW-1:0] adc;
  logic wr_en_o, rec_done_o, acq_done_o, busy_o, pre_short_o;
  logic [AW-1:0] wr_addr_o, rd_start_o;
  logic [DW-1:0] wr_data_o;

  int checks = 0, fails = 0, wcnt = 0, rdcnt = 0;
  int wlog[64];
  int alog[64];
  int mem[DEPTH];
  bit finished = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) adc <= '0; else adc <= adc + 1'b1;

  acq_trig_seq #(.DW(DW), .CW(CW), .AW(AW), .RW(RW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .mode_i(mode), .src_i(src), .fall_i(fall), .retrig_i(retrig),
    .scan_i(scan), .n_i(n), .dly_i(dly), .pre_i(pre), .rec_i(recs),
    .sw_trig_i(sw), .ext_trig_i(ext), .ana_trig_i(ana), .sync_trig_i(syn),
    .adc_data_i(adc), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .rec_done_o(rec_done_o), .acq_done_o(acq_done_o), .busy_o(busy_o),
    .rd_start_o(rd_start_o), .pre_short_o(pre_short_o)
  );

  always @(negedge clk) if (rst_n) begin
    if (wr_en_o) begin
      mem[wr_addr_o] = int'(wr_data_o);
      if (wcnt < 64) begin
        wlog[wcnt] = int'(wr_data_o);
        alog[wcnt] = int'(wr_addr_o);
      end
      wcnt++;
    end
    if (rec_done_o) rdcnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_acq(input int m, input int s, input int f, input int nn, input int d,
                           input int p, input int r, input int rt, input int sc, output int st);
    @(negedge clk);
    mode = 2'(m); src = 2'(s); fall = f[0]; n = CW'(nn); dly = CW'(d); pre = CW'(p);
    recs = RW'(r); retrig = rt[0]; scan = CW'(sc);
    wcnt = 0; rdcnt = 0;
    start = 1; st = int'(adc);
    @(negedge clk);
    start = 0;
  endtask

  task automatic pulse_sw(output int t);
    @(negedge clk); sw = 1; t = int'(adc);
    @(negedge clk); sw = 0;
  endtask

  task automatic do_abort(output int a);
    @(negedge clk); abort = 1; a = int'(adc);
    @(negedge clk); abort = 0;
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (!acq_done_o && k < 3000) begin @(negedge clk); k++; end
    chk(k < 3000, tag, k, 3000);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_ring(input int len, input int first, input string tag);
    for (int i = 0; i < len; i++)
      chk(mem[(int'(rd_start_o) + i) % DEPTH] == first + i, tag,
          mem[(int'(rd_start_o) + i) % DEPTH], first + i);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int s, t, a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !wr_en_o && !rec_done_o && !acq_done_o && !pre_short_o, "R1", busy_o, 0);

    // R3 R5 R7 R12 post-mode sweep
    for (int sc = 1; sc <= 3; sc++)
      for (int nn = 1; nn <= 4; nn++) begin
        start_acq(0, 0, 0, nn, 0, 0, 1, 0, sc, s);
        chk(busy_o && !acq_done_o, "R2", busy_o, 1);
        repeat (2) @(negedge clk);
        pulse_sw(t);
        wait_done("R12 timeout");
        chk(wcnt == nn, "R7 count", wcnt, nn);
        chk(wlog[0] == t + 1, "R5 first", wlog[0], t + 1);
        for (int i = 1; i < nn; i++) begin
          chk(wlog[i] - wlog[i-1] == sc, "R3 spacing", wlog[i] - wlog[i-1], sc);
          chk(alog[i] == i, "R7 addr", alog[i], i);
        end
        chk(alog[0] == 0, "R7 addr0", alog[0], 0);
        chk(rdcnt == 1 && acq_done_o && !busy_o, "R12", rdcnt, 1);
      end

    // R8 delayed mode
    for (int di = 0; di < 4; di++) begin
      int d = (di == 3) ? 9 : di * 2;
      start_acq(1, 0, 0, 2, d, 0, 1, 0, 1, s);
      pulse_sw(t);
      wait_done("R8 timeout");
      chk(wcnt == 2 && wlog[0] == t + 2 + d, "R8 first", wlog[0], t + 2 + d);
    end

    // R4 unselected lines ignored, then R6 external rising
    start_acq(0, 1, 0, 2, 0, 0, 1, 0, 1, s);
    pulse_sw(t);
    @(negedge clk); ana = 1; syn = 1;
    repeat (6) @(negedge clk); ana = 0; syn = 0;
    repeat (6) @(negedge clk);
    chk(wcnt == 0 && busy_o, "R4", wcnt, 0);
    @(negedge clk); ext = 1; t = int'(adc);
    wait_done("R6 timeout");
    chk(wlog[0] == t + 3, "R6 ext rise", wlog[0], t + 3);
    ext = 0;

    // R6 falling edge on external
    @(negedge clk); ext = 1;
    repeat (4) @(negedge clk);
    start_acq(0, 1, 1, 2, 0, 0, 1, 0, 1, s);
    repeat (3) @(negedge clk);
    ext = 0; t = int'(adc);
    wait_done("R6 timeout");
    chk(wlog[0] == t + 3, "R6 ext fall", wlog[0], t + 3);

    // R4 R6 analog and sync sources
    start_acq(0, 2, 0, 1, 0, 0, 1, 0, 1, s);
    repeat (3) @(negedge clk);
    ana = 1; t = int'(adc);
    wait_done("R4 timeout");
    chk(wlog[0] == t + 3, "R4 analog", wlog[0], t + 3);
    ana = 0;
    start_acq(0, 3, 0, 1, 0, 0, 1, 0, 1, s);
    repeat (3) @(negedge clk);
    syn = 1; t = int'(adc);
    wait_done("R4 timeout");
    chk(wlog[0] == t + 3, "R4 sync", wlog[0], t + 3);
    syn = 0;

    // R9 pre mode, trigger coincides with a ring write
    for (int k = 0; k < 3; k++) begin
      int nn = 1 + 2 * k;
      start_acq(2, 0, 0, nn, 0, 0, 1, 0, 1, s);
      repeat (nn + 2) @(negedge clk);
      pulse_sw(t);
      wait_done("R9 timeout");
      chk(!pre_short_o, "R9 short", pre_short_o, 0);
      chk_ring(nn, t - nn + 1, "R9 record");
    end
    // R9 ring wraps
    start_acq(2, 0, 0, 4, 0, 0, 1, 0, 1, s);
    repeat (40) @(negedge clk);
    pulse_sw(t);
    wait_done("R9 timeout");
    chk(wcnt > DEPTH, "R9 wrap", wcnt, DEPTH + 1);
    chk_ring(4, t - 3, "R9 wrap record");

    // R10 middle mode, full and short history
    start_acq(3, 0, 0, 6, 0, 2, 1, 0, 1, s);
    repeat (5) @(negedge clk);
    pulse_sw(t);
    wait_done("R10 timeout");
    chk(!pre_short_o, "R10 flag", pre_short_o, 0);
    chk_ring(6, t - 1, "R10 record");
    start_acq(3, 0, 0, 6, 0, 4, 1, 0, 1, s);
    pulse_sw(t);
    wait_done("R10 timeout");
    chk(pre_short_o, "R10 short flag", pre_short_o, 1);
    chk(t == s + 2, "R10 setup", t, s + 2);
    chk_ring(4, s + 1, "R10 short record");

    // R11 re-trigger with held software trigger, post mode
    start_acq(0, 0, 0, 3, 0, 0, 3, 1, 1, s);
    @(negedge clk); sw = 1; t = int'(adc);
    wait_done("R11 timeout");
    sw = 0;
    chk(wcnt == 9 && rdcnt == 3, "R11 count", wcnt, 9);
    for (int r = 0; r < 3; r++)
      chk(wlog[3 * r] == t + 1 + 4 * r, "R11 post spacing", wlog[3 * r], t + 1 + 4 * r);
    // R11 delayed re-trigger spacing
    start_acq(1, 0, 0, 2, 2, 0, 2, 1, 1, s);
    @(negedge clk); sw = 1; t = int'(adc);
    wait_done("R11 timeout");
    sw = 0;
    for (int r = 0; r < 2; r++)
      chk(wlog[2 * r] == t + 4 + 6 * r, "R11 delay spacing", wlog[2 * r], t + 4 + 6 * r);
    // R11 trigger during capture ignored
    start_acq(0, 0, 0, 4, 0, 0, 2, 1, 1, s);
    pulse_sw(t);
    pulse_sw(a);
    repeat (7) @(negedge clk);
    chk(wcnt == 4 && busy_o, "R11 ignored", wcnt, 4);
    pulse_sw(a);
    wait_done("R11 timeout");
    chk(wlog[4] == a + 1 && rdcnt == 2, "R11 rearm", wlog[4], a + 1);
    // R11 re-trigger ignored in pre mode
    start_acq(2, 0, 0, 2, 0, 0, 3, 1, 1, s);
    repeat (3) @(negedge clk);
    pulse_sw(t);
    wait_done("R11 timeout");
    chk(rdcnt == 1 && !busy_o, "R11 pre single", rdcnt, 1);

    // R13 abort while armed
    start_acq(0, 0, 0, 3, 0, 0, 1, 0, 1, s);
    do_abort(a);
    chk(!busy_o, "R13 busy", busy_o, 0);
    pulse_sw(t);
    repeat (6) @(negedge clk);
    chk(wcnt == 0 && !acq_done_o, "R13 armed", wcnt, 0);
    // R13 abort during capture
    start_acq(0, 0, 0, 10, 0, 0, 1, 0, 1, s);
    pulse_sw(t);
    repeat (3) @(negedge clk);
    do_abort(a);
    repeat (6) @(negedge clk);
    chk(wcnt == a - 1 - t, "R13 capture", wcnt, a - 1 - t);
    chk(!busy_o && !acq_done_o, "R13 idle", busy_o, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule